// File: doc/BRIEF.md
# Lockable Translation Lookaside Buffer

This block is a small, fully associative cache of virtual-to-physical page translations for 4 KB pages. A lookup port presents a 32-bit virtual address and an access type. In the same cycle the block answers with a hit and the physical address and permission bits, or with a miss. Results come from registered entry state only.

Entries are written from a walk response port. A response that arrives while no lock is pending is an ordinary fill. It goes to a round-robin victim chosen only among entries that are not pinned. A maintenance channel with a valid/ready handshake accepts four operations: flush all, flush one entry by page, pin (lock) a page, and clear the fault register. A lock operation raises a walk request for the page. The next walk response installs the page as a pinned entry. If that response reports an abort, the fault register is loaded with a dedicated lock-abort code and a data-abort pulse is raised. Each pinned entry removes one slot from the pool that ordinary fills may use.

Top module: `lock_tlb`

## Requirements
- R1: With `lk_valid_i` high, exactly one of `lk_hit_o`/`lk_miss_o` is high in the same cycle. A hit means a valid entry holds `lk_vaddr_i[31:12]`. On a hit, `lk_paddr_o` is {stored page, `lk_vaddr_i[11:0]`} and `lk_perm_o` is the stored permission pair. When there is no hit, both of these outputs are zero, and all lookup outputs are zero when `lk_valid_i` is low. After reset no entry is valid and `fsr_o` is 0.
- R2: Permission bit 0 allows reads and bit 1 allows writes. `lk_deny_o` is high on a hit whose access (`lk_write_i`=1 write, 0 read) is not allowed.
- R3: An ordinary fill (`wr_valid_i` with no lock pending and `wr_abort_i` low) whose page is resident overwrites that entry's page and permissions in place. Otherwise it installs an unpinned valid entry at the first unpinned index at or after the replacement pointer, wrapping from 7 to 0, and moves the pointer to the next index after it. An ordinary response with `wr_abort_i` high changes nothing.
- R4: When all 8 entries are pinned, an ordinary fill of a new page is dropped, and lookups of that page keep missing.
- R5: A pinned entry is never chosen as a victim, so it keeps its page until it is released.
- R6: Flush-all (`cmd_op_i`=0) clears only unpinned entries, and pinned pages keep hitting.
- R7: Flush-one (`cmd_op_i`=1) clears both the valid and the pin state of the entry holding `cmd_vpn_i`.
- R8: After a lock (`cmd_op_i`=2) is accepted, `walk_req_o` is high and `walk_vpn_o` equals the page from the next cycle until the response edge. A non-aborting response then installs a pinned valid entry at the victim index and advances the pointer.
- R9: A lock response with `wr_abort_i` high writes no entry, loads `fsr_o` with 4'hC, and pulses `data_abort_o` for the one cycle after the response.
- R10: `fsr_o` keeps its value through misses, fills and other commands, and returns to 0 only through clear-fault (`cmd_op_i`=3).
- R11: A lock accepted while every entry is pinned (or while its page is resident) starts no walk and pulses `lock_err_o` for one cycle.
- R12: `cmd_ready_o` is high only when no lock is pending and `wr_valid_i` is low. Commands presented while it is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_write_i | input | 1 | Lookup access type, 1 = write |
| lk_vaddr_i | input | 32 | Lookup virtual address |
| lk_hit_o | output | 1 | Lookup hit |
| lk_miss_o | output | 1 | Lookup miss |
| lk_deny_o | output | 1 | Hit without permission for the access |
| lk_paddr_o | output | 32 | Translated physical address |
| lk_perm_o | output | 2 | Permission bits of the hit entry |
| cmd_valid_i | input | 1 | Maintenance command valid |
| cmd_ready_o | output | 1 | Maintenance command ready |
| cmd_op_i | input | 2 | 0 flush all, 1 flush one, 2 lock, 3 clear fault |
| cmd_vpn_i | input | 20 | Page number for flush-one and lock |
| walk_req_o | output | 1 | Lock walk pending |
| walk_vpn_o | output | 20 | Page being walked for the lock |
| wr_valid_i | input | 1 | Walk response valid |
| wr_abort_i | input | 1 | Walk response aborted |
| wr_vpn_i | input | 20 | Page of an ordinary fill |
| wr_ppn_i | input | 20 | Physical page of the response |
| wr_perm_i | input | 2 | Permission bits of the response |
| fsr_o | output | 4 | Fault status |
| data_abort_o | output | 1 | Data-abort pulse on a lock abort |
| lock_err_o | output | 1 | Rejected-lock pulse |

## Verification
The hardest state to reach is a fully pinned buffer. Random traffic keeps releasing entries, so it seldom pins all eight pages at once. A directed phase therefore pins pages until none is left. It then checks that an ordinary fill is dropped, that a further lock is rejected, and that flush-all leaves every pinned page hitting. It then releases one pin and confirms that the next fill lands in exactly that slot. Around this phase, seeded random traffic mixes fills, overlapping commands, aborted and successful lock walks, and commands held while not ready. A reference model tracks the replacement pointer and every entry.

// File: rtl/lock_tlb_pkg.sv
package lock_tlb_pkg;
  localparam int unsigned VA_W   = 32;
  localparam int unsigned PG_OFS = 12;
  localparam int unsigned VPN_W  = VA_W - PG_OFS;
  localparam int unsigned PPN_W  = 20;
  localparam int unsigned PERM_W = 2;
  localparam int unsigned FSR_W  = 4;
  localparam logic [FSR_W-1:0] FSR_LOCK_ABORT = 4'hC;

  typedef enum logic [1:0] {
    OP_INV_ALL   = 2'b00,
    OP_INV_ONE   = 2'b01,
    OP_LOCK      = 2'b10,
    OP_CLR_FAULT = 2'b11
  } tlb_op_e;

  typedef enum logic {ST_IDLE, ST_WAIT} tlb_state_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int unsigned N     = 8,
  parameter int unsigned KEY_W = 20,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]            valid_i,
  input  logic [N-1:0][KEY_W-1:0] key_arr_i,
  input  logic [KEY_W-1:0]        key_i,
  output logic                    hit_o,
  output logic [IDX_W-1:0]        idx_o
);
  logic [N-1:0] hit_vec;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = valid_i[g] && (key_arr_i[g] == key_i);
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |hit_vec;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     lock_i,
  input  logic [IDX_W-1:0] ptr_i,
  output logic [IDX_W-1:0] victim_o,
  output logic             free_o
);
  logic [IDX_W:0]   sum;
  logic [IDX_W-1:0] idx;

  // scan downward so the smallest distance from ptr wins
  always_comb begin
    victim_o = ptr_i;
    free_o   = 1'b0;
    sum      = '0;
    idx      = '0;
    for (int k = N - 1; k >= 0; k--) begin
      sum = {1'b0, ptr_i} + (IDX_W + 1)'(k);
      if (sum >= (IDX_W + 1)'(N)) sum = sum - (IDX_W + 1)'(N);
      idx = sum[IDX_W-1:0];
      if (!lock_i[idx]) begin
        victim_o = idx;
        free_o   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lock_tlb.sv
module lock_tlb
  import lock_tlb_pkg::*;
#(
  parameter int unsigned N_ENTRY = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic              lk_write_i,
  input  logic [VA_W-1:0]   lk_vaddr_i,
  output logic              lk_hit_o,
  output logic              lk_miss_o,
  output logic              lk_deny_o,
  output logic [VA_W-1:0]   lk_paddr_o,
  output logic [PERM_W-1:0] lk_perm_o,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [1:0]        cmd_op_i,
  input  logic [VPN_W-1:0]  cmd_vpn_i,
  output logic              walk_req_o,
  output logic [VPN_W-1:0]  walk_vpn_o,
  input  logic              wr_valid_i,
  input  logic              wr_abort_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [PPN_W-1:0]  wr_ppn_i,
  input  logic [PERM_W-1:0] wr_perm_i,
  output logic [FSR_W-1:0]  fsr_o,
  output logic              data_abort_o,
  output logic              lock_err_o
);
  localparam int unsigned IDX_W = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1;

  logic [N_ENTRY-1:0]              valid_q, lock_q;
  logic [N_ENTRY-1:0][VPN_W-1:0]   vpn_q;
  logic [N_ENTRY-1:0][PPN_W-1:0]   ppn_q;
  logic [N_ENTRY-1:0][PERM_W-1:0]  perm_q;
  logic [IDX_W-1:0]                ptr_q;
  tlb_state_e                      state_q;
  logic [VPN_W-1:0]                pend_q;
  logic [FSR_W-1:0]                fsr_q;
  logic                            abort_q, err_q;

  tlb_op_e          op;
  logic             cmd_fire;
  logic             lk_hit_s, st_hit;
  logic [IDX_W-1:0] lk_idx, st_idx, vic;
  logic             vic_free;
  logic [VPN_W-1:0] st_key;

  function automatic logic [IDX_W-1:0] step_ptr(input logic [IDX_W-1:0] v);
    return (v == IDX_W'(N_ENTRY - 1)) ? '0 : v + 1'b1;
  endfunction

  assign op          = tlb_op_e'(cmd_op_i);
  assign cmd_ready_o = (state_q == ST_IDLE) && !wr_valid_i;
  assign cmd_fire    = cmd_valid_i && cmd_ready_o;
  // fills and commands are never accepted together, so one store-side port suffices
  assign st_key      = wr_valid_i ? wr_vpn_i : cmd_vpn_i;

  tlb_match #(.N(N_ENTRY), .KEY_W(VPN_W), .IDX_W(IDX_W)) i_lk_match (
    .valid_i  (valid_q),
    .key_arr_i(vpn_q),
    .key_i    (lk_vaddr_i[VA_W-1:PG_OFS]),
    .hit_o    (lk_hit_s),
    .idx_o    (lk_idx)
  );

  tlb_match #(.N(N_ENTRY), .KEY_W(VPN_W), .IDX_W(IDX_W)) i_st_match (
    .valid_i  (valid_q),
    .key_arr_i(vpn_q),
    .key_i    (st_key),
    .hit_o    (st_hit),
    .idx_o    (st_idx)
  );

  tlb_victim #(.N(N_ENTRY), .IDX_W(IDX_W)) i_victim (
    .lock_i  (lock_q),
    .ptr_i   (ptr_q),
    .victim_o(vic),
    .free_o  (vic_free)
  );

  // lookup path: combinational on registered entries
  always_comb begin
    lk_hit_o   = lk_valid_i && lk_hit_s;
    lk_miss_o  = lk_valid_i && !lk_hit_s;
    lk_perm_o  = lk_hit_o ? perm_q[lk_idx] : '0;
    lk_paddr_o = lk_hit_o ? {ppn_q[lk_idx], lk_vaddr_i[PG_OFS-1:0]} : '0;
    lk_deny_o  = lk_hit_o && (lk_write_i ? !lk_perm_o[1] : !lk_perm_o[0]);
  end

  assign walk_req_o   = (state_q == ST_WAIT);
  assign walk_vpn_o   = pend_q;
  assign fsr_o        = fsr_q;
  assign data_abort_o = abort_q;
  assign lock_err_o   = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      lock_q  <= '0;
      vpn_q   <= '0;
      ppn_q   <= '0;
      perm_q  <= '0;
      ptr_q   <= '0;
      state_q <= ST_IDLE;
      pend_q  <= '0;
      fsr_q   <= '0;
      abort_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      abort_q <= 1'b0;
      err_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (wr_valid_i) begin
            if (!wr_abort_i) begin
              if (st_hit) begin
                ppn_q[st_idx]  <= wr_ppn_i;
                perm_q[st_idx] <= wr_perm_i;
              end else if (vic_free) begin
                valid_q[vic] <= 1'b1;
                lock_q[vic]  <= 1'b0;
                vpn_q[vic]   <= wr_vpn_i;
                ppn_q[vic]   <= wr_ppn_i;
                perm_q[vic]  <= wr_perm_i;
                ptr_q        <= step_ptr(vic);
              end
            end
          end else if (cmd_fire) begin
            unique case (op)
              OP_INV_ALL: valid_q <= valid_q & lock_q;
              OP_INV_ONE: begin
                if (st_hit) begin
                  valid_q[st_idx] <= 1'b0;
                  lock_q[st_idx]  <= 1'b0;
                end
              end
              OP_LOCK: begin
                if (st_hit || !vic_free) begin
                  err_q <= 1'b1;
                end else begin
                  state_q <= ST_WAIT;
                  pend_q  <= cmd_vpn_i;
                end
              end
              OP_CLR_FAULT: fsr_q <= '0;
            endcase
          end
        end
        ST_WAIT: begin
          // commands are held off, so the victim chosen at accept is still free
          if (wr_valid_i) begin
            state_q <= ST_IDLE;
            if (wr_abort_i) begin
              fsr_q   <= FSR_LOCK_ABORT;
              abort_q <= 1'b1;
            end else begin
              valid_q[vic] <= 1'b1;
              lock_q[vic]  <= 1'b1;
              vpn_q[vic]   <= pend_q;
              ppn_q[vic]   <= wr_ppn_i;
              perm_q[vic]  <= wr_perm_i;
              ptr_q        <= step_ptr(vic);
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/lock_tlb_chk.sv
module lock_tlb_chk
  import lock_tlb_pkg::*;
#(
  parameter int unsigned N_ENTRY = 8
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           lk_valid_i,
  input logic                           lk_hit_o,
  input logic                           lk_miss_o,
  input logic                           cmd_valid_i,
  input logic                           cmd_ready_o,
  input logic [1:0]                     cmd_op_i,
  input logic                           walk_req_o,
  input logic [VPN_W-1:0]               walk_vpn_o,
  input logic                           wr_valid_i,
  input logic                           wr_abort_i,
  input logic [FSR_W-1:0]               fsr_o,
  input logic                           data_abort_o,
  input logic [N_ENTRY-1:0]             valid_q,
  input logic [N_ENTRY-1:0]             lock_q,
  input logic [N_ENTRY-1:0][VPN_W-1:0]  vpn_q
);
  logic fire, clr_fire, inv_one_fire, lock_abort;
  assign fire         = cmd_valid_i && cmd_ready_o;
  assign clr_fire     = fire && (cmd_op_i == OP_CLR_FAULT);
  assign inv_one_fire = fire && (cmd_op_i == OP_INV_ONE);
  assign lock_abort   = walk_req_o && wr_valid_i && wr_abort_i;

  p_hit_xor_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |-> (lk_hit_o ^ lk_miss_o));
  p_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |-> (!lk_hit_o && !lk_miss_o));
  p_wait_blocks_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_req_o |-> !cmd_ready_o);
  p_walk_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (walk_req_o && !wr_valid_i) |=> (walk_req_o && $stable(walk_vpn_o)));
  p_abort_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_abort |=> (data_abort_o && fsr_o == FSR_LOCK_ABORT));
  p_abort_code_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_abort_o |-> (fsr_o == FSR_LOCK_ABORT));
  p_fsr_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_fire && !lock_abort) |=> $stable(fsr_o));

  for (genvar g = 0; g < N_ENTRY; g++) begin : g_ent
    p_lock_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock_q[g] |-> valid_q[g]);
    p_lock_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_q[g] && !inv_one_fire) |=> (lock_q[g] && $stable(vpn_q[g])));
  end
endmodule

bind lock_tlb lock_tlb_chk #(.N_ENTRY(N_ENTRY)) i_lock_tlb_chk (.*);

// File: tb/test_lock_tlb.sv
module test_lock_tlb;
  import lock_tlb_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic lk_v, lk_w, cv, wv, wab;
  logic [31:0] lk_va;
  logic [1:0] cop, wperm;
  logic [19:0] cvpn, wvpn, wppn;
  logic hit, miss, deny, ready, wreq, dab, lerr;
  logic [31:0] paddr;
  logic [1:0] perm;
  logic [19:0] wvpn_o;
  logic [3:0] fsr;

  lock_tlb i_lock_tlb (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_v), .lk_write_i(lk_w), .lk_vaddr_i(lk_va),
    .lk_hit_o(hit), .lk_miss_o(miss), .lk_deny_o(deny),
    .lk_paddr_o(paddr), .lk_perm_o(perm),
    .cmd_valid_i(cv), .cmd_ready_o(ready), .cmd_op_i(cop), .cmd_vpn_i(cvpn),
    .walk_req_o(wreq), .walk_vpn_o(wvpn_o),
    .wr_valid_i(wv), .wr_abort_i(wab), .wr_vpn_i(wvpn), .wr_ppn_i(wppn),
    .wr_perm_i(wperm),
    .fsr_o(fsr), .data_abort_o(dab), .lock_err_o(lerr)
  );

  int checks = 0, errors = 0;
  string ctx = "R1";

  bit m_valid[N], m_lock[N];
  logic [19:0] m_vpn[N], m_ppn[N];
  logic [1:0] m_perm[N];
  int m_ptr = 0;
  logic [3:0] m_fsr = 4'h0;
  bit m_wait = 0, e_abort = 0, e_err = 0;
  logic [19:0] m_pend = '0;

  function automatic int find(logic [19:0] v);
    for (int i = 0; i < N; i++) if (m_valid[i] && m_vpn[i] == v) return i;
    return -1;
  endfunction

  function automatic int victim();
    for (int k = 0; k < N; k++) if (!m_lock[(m_ptr + k) % N]) return (m_ptr + k) % N;
    return -1;
  endfunction

  task automatic chk(string r, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", r, what, act, exp);
    end
  endtask

  task automatic clr_in();
    lk_v = 0; lk_w = 0; lk_va = '0; cv = 0; cop = '0; cvpn = '0;
    wv = 0; wab = 0; wvpn = '0; wppn = '0; wperm = '0;
  endtask

  task automatic install(int v, logic [19:0] vpn, bit lck);
    m_valid[v] = 1; m_lock[v] = lck; m_vpn[v] = vpn;
    m_ppn[v] = wppn; m_perm[v] = wperm; m_ptr = (v + 1) % N;
  endtask

  // inputs are set by the caller just after a falling edge
  task automatic tick();
    int idx, v;
    logic [1:0] ep;
    bit eh;
    #1;
    idx = find(lk_va[31:12]);
    eh = lk_v && idx >= 0;
    ep = eh ? m_perm[idx] : 2'b00;
    chk(ctx, "hit", hit, eh);
    chk(ctx, "miss", miss, lk_v && idx < 0);
    chk(ctx, "paddr", paddr, eh ? {m_ppn[idx], lk_va[11:0]} : 32'h0);
    chk(ctx, "perm", perm, ep);
    chk("R2", "deny", deny, eh && (lk_w ? !ep[1] : !ep[0]));
    chk("R12", "ready", ready, !m_wait && !wv);
    chk("R8", "walk_req", wreq, m_wait);
    if (m_wait) chk("R8", "walk_vpn", wvpn_o, m_pend);
    chk("R10", "fsr", fsr, m_fsr);
    chk("R9", "data_abort", dab, e_abort);
    chk("R11", "lock_err", lerr, e_err);
    @(posedge clk);
    e_abort = 0; e_err = 0;
    if (!m_wait) begin
      if (wv) begin
        if (!wab) begin
          idx = find(wvpn);
          if (idx >= 0) begin m_ppn[idx] = wppn; m_perm[idx] = wperm; end
          else begin v = victim(); if (v >= 0) install(v, wvpn, 0); end
        end
      end else if (cv) begin
        case (cop)
          2'd0: for (int i = 0; i < N; i++) if (!m_lock[i]) m_valid[i] = 0;
          2'd1: begin idx = find(cvpn); if (idx >= 0) begin m_valid[idx] = 0; m_lock[idx] = 0; end end
          2'd2: if (find(cvpn) >= 0 || victim() < 0) e_err = 1;
                else begin m_wait = 1; m_pend = cvpn; end
          default: m_fsr = 4'h0;
        endcase
      end
    end else if (wv) begin
      m_wait = 0;
      if (wab) begin m_fsr = 4'hC; e_abort = 1; end
      else install(victim(), m_pend, 1);
    end
    @(negedge clk);
  endtask

  task automatic look(logic [19:0] vpn, bit w);
    clr_in(); lk_v = 1; lk_w = w; lk_va = {vpn, 12'($urandom)}; tick();
  endtask
  task automatic fill(logic [19:0] vpn, logic [19:0] ppn, logic [1:0] pm, bit ab);
    clr_in(); wv = 1; wvpn = vpn; wppn = ppn; wperm = pm; wab = ab; tick();
  endtask
  task automatic cmd(logic [1:0] op, logic [19:0] vpn);
    clr_in(); cv = 1; cop = op; cvpn = vpn; tick();
  endtask
  task automatic lock_pg(logic [19:0] vpn, logic [19:0] ppn, bit ab);
    cmd(2'd2, vpn);
    look(vpn, 0);
    fill(20'h0, ppn, 2'b11, ab);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0; m_lock[i] = 0; m_vpn[i] = '0; m_ppn[i] = '0; m_perm[i] = '0;
    end
    clr_in();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state, nothing resident
    ctx = "R1"; look(20'h1, 0); look(20'h0, 1);
    // R3: fills, lookups, in-place overwrite
    ctx = "R3";
    for (int i = 1; i <= 8; i++) fill(20'(i), 20'(32'h100 + i), 2'(i), 0);
    for (int i = 1; i <= 9; i++) look(20'(i), i[0]);
    fill(20'h3, 20'hABCDE, 2'b10, 0); look(20'h3, 0); look(20'h3, 1);
    fill(20'h9, 20'h55555, 2'b11, 1); look(20'h9, 0);
    fill(20'hA, 20'h22222, 2'b01, 0); look(20'h1, 0); look(20'hA, 1);
    ctx = "R2"; look(20'hA, 0); look(20'h2, 1);
    // R8: lock walk
    ctx = "R8"; lock_pg(20'h20, 20'h77777, 0); look(20'h20, 1);
    // R9, R10: aborted lock, fault kept, then cleared
    ctx = "R9"; lock_pg(20'h40, 20'h1, 1); look(20'h40, 0);
    ctx = "R10"; look(20'h55, 0); fill(20'h41, 20'h2, 2'b11, 0); cmd(2'd0, 20'h0);
    cmd(2'd3, 20'h0); look(20'h41, 0);
    // R5, R4, R11: pin every slot, then fills are dropped and locks rejected
    ctx = "R5";
    for (int i = 0; i < 7; i++) lock_pg(20'(32'h50 + i), 20'(32'h300 + i), 0);
    look(20'h20, 0);
    for (int i = 0; i < 7; i++) look(20'(32'h50 + i), 0);
    ctx = "R4"; fill(20'h70, 20'h9, 2'b11, 0); look(20'h70, 0);
    ctx = "R11"; cmd(2'd2, 20'h71); look(20'h71, 0);
    // R6: flush all leaves pinned pages
    ctx = "R6"; cmd(2'd0, 20'h0); look(20'h20, 0); look(20'h56, 1);
    // R7: release one pin, next fill lands there
    ctx = "R7"; cmd(2'd1, 20'h53); look(20'h53, 0);
    fill(20'h80, 20'h8, 2'b01, 0); look(20'h80, 0); look(20'h54, 0);
    // R12: commands held off while a lock walk is pending or a fill arrives
    ctx = "R12"; cmd(2'd1, 20'h54); cmd(2'd2, 20'h90);
    clr_in(); cv = 1; cop = 2'd3; tick();
    clr_in(); wv = 1; wppn = 20'h91; wperm = 2'b11; cv = 1; cop = 2'd0; tick();
    look(20'h90, 0); look(20'h55, 0);
    clr_in(); wv = 1; wvpn = 20'h92; wppn = 20'h5; wperm = 2'b11; cv = 1; cop = 2'd1; cvpn = 20'h55; tick();
    look(20'h55, 0); look(20'h92, 0);
    for (int i = 0; i < 8; i++) cmd(2'd1, 20'(32'h50 + i));
    cmd(2'd1, 20'h20); cmd(2'd1, 20'h90);
    // seeded random traffic
    ctx = "R1";
    for (int n = 0; n < 4000; n++) begin
      automatic int r = $urandom_range(0, 9);
      automatic logic [19:0] pg = 20'($urandom_range(0, 15));
      clr_in();
      lk_v = ($urandom_range(0, 3) != 0); lk_w = 1'($urandom);
      lk_va = {20'($urandom_range(0, 15)), 12'($urandom)};
      if (m_wait) begin
        cv = 1'($urandom); cop = 2'($urandom); cvpn = pg;
        if ($urandom_range(0, 2) == 0) begin
          wv = 1; wab = ($urandom_range(0, 4) == 0); wppn = 20'($urandom); wperm = 2'($urandom);
        end
      end else if (r <= 3) begin
        wv = 1; wab = ($urandom_range(0, 9) == 0); wvpn = pg; wppn = 20'($urandom);
        wperm = 2'($urandom); cv = 1'($urandom); cop = 2'($urandom);
      end else if (r <= 6) begin
        if (find(pg) >= 0) begin cv = 1; cop = 2'd1; cvpn = pg; tick(); clr_in(); end
        cv = 1; cop = 2'd2; cvpn = pg;
      end else if (r == 7) begin
        cv = 1; cop = 2'd1; cvpn = pg;
      end else begin
        cv = 1; cop = ($urandom_range(0, 3) == 0) ? 2'd0 : 2'd3;
      end
      tick();
    end
    clr_in(); tick();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule